// File: doc/BRIEF.md
# Frame-Timed Instruction Sequencer

This block runs a short program of 16-bit instruction words against a free-running frame time base. The time base advances by one quarter-bit tick on every clock and wraps from 4999 back to 0. A host fills a local instruction memory and then sets the enable bit. The sequencer then fetches from address 0. Some instructions stall until the frame time reaches a given value, or for a given number of ticks. Others load the SYNCHRO or OFFSET time registers, or write a byte into a 32-entry internal register file. Two entries of that register file drive the DSP interrupt flag and the gauging enable. A SLEEP instruction makes the sequencer clear its own enable bit and go idle.

The host can also restart the fetch pointer at address 0 with a rewind pulse. It can read any internal register and the two time registers, and it can enable a frame interrupt that pulses when the time base wraps.

Instruction word layout: bits 15:13 are the opcode and bits 12:0 are the operand. For MOVE, bits 12:5 are the data byte and bits 4:0 are the internal address.

Top module: `frame_seq`

## Requirements
- R1: During and after reset: `idle` is 1; `synchro_val`, `offset_val`, `frame_time`, `frame_irq`, `dsp_irq` and `gauge_en` are 0; every internal register reads 0.
- R2: `frame_time` increases by one on every clock and goes from 4999 to 0.
- R3: `frame_irq` is high for exactly the one cycle in which `frame_time` is 0 after a wrap, and only if `host_frame_irq_en` was high in the cycle where `frame_time` was 4999. It is low otherwise.
- R4: `idle` is the inverse of the enable bit. A host control write with `host_ctl_enable`=1 while idle sets the bit. Execution then begins at address 0 in the next cycle, one instruction per cycle. A control write with `host_ctl_enable`=0 clears the bit.
- R5: SLEEP (opcode 0) clears the enable bit, so `idle` rises the next cycle. The instructions that follow it have no effect.
- R6: AT (opcode 1) holds execution until `frame_time` equals operand bits 12:0. The next instruction executes in the following cycle. This includes a target that needs the time base to wrap first.
- R7: WAIT (opcode 5) with operand N delays the next instruction by N cycles. With N=0 the next instruction follows in the next cycle.
- R8: SYNCHRO (opcode 3) loads bits 12:0 into `synchro_val`, and OFFSET (opcode 2) loads bits 12:0 into `offset_val`. Each value is visible in the cycle after the instruction executes.
- R9: MOVE (opcode 4) writes bits 12:5 into the internal register addressed by bits 4:0. This register is readable on `host_reg_data`. Bit 0 of register 0x10 drives `dsp_irq` and bit 0 of register 0x11 drives `gauge_en`.
- R10: Opcodes 6 and 7 change no register and no output; execution moves to the next address.
- R11: A `host_rewind` pulse sets the fetch pointer to 0 and cancels any WAIT in progress. The instruction at address 0 executes in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one quarter-bit tick per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_imem_we | input | 1 | Instruction memory write strobe |
| host_imem_addr | input | 6 | Instruction memory write address |
| host_imem_data | input | 16 | Instruction word to write |
| host_ctl_we | input | 1 | Control write strobe for the enable bit |
| host_ctl_enable | input | 1 | Enable bit value written by a control write |
| host_rewind | input | 1 | Restart fetching at address 0 |
| host_frame_irq_en | input | 1 | Frame interrupt enable |
| host_reg_addr | input | 5 | Internal register read address |
| host_reg_data | output | 8 | Internal register read data |
| synchro_val | output | 13 | SYNCHRO register |
| offset_val | output | 13 | OFFSET register |
| frame_time | output | 13 | Current frame time, 0 to 4999 |
| idle | output | 1 | High when the enable bit is clear |
| frame_irq | output | 1 | One-cycle pulse at frame wrap |
| dsp_irq | output | 1 | DSP interrupt flag |
| gauge_en | output | 1 | Gauging enable |

## Verification
The hardest case to reach is an AT whose target lies behind the current frame time. It must stall across the 4999-to-0 wrap rather than match early or never. The bench starts a program ten ticks before the wrap, with a target of 5. It then checks that the next SYNCHRO lands exactly two ticks after the target. A WAIT interrupted by a rewind is reached in a similar way. The bench overwrites address 0 while a long WAIT is pending, then pulses rewind. The new word must take effect in the next cycle instead of thousands of ticks later.

// File: rtl/ftseq_pkg.sv
package ftseq_pkg;
    localparam int INSTR_W   = 16;
    localparam int OPND_W    = 13;
    localparam int MV_ADDR_W = 5;
    localparam int MV_DATA_W = 8;

    typedef enum logic [2:0] {
        OP_SLEEP   = 3'd0,
        OP_AT      = 3'd1,
        OP_OFFSET  = 3'd2,
        OP_SYNCHRO = 3'd3,
        OP_MOVE    = 3'd4,
        OP_WAIT    = 3'd5,
        OP_RSV6    = 3'd6,
        OP_RSV7    = 3'd7
    } op_e;
endpackage

// File: rtl/ftseq_timebase.sv
module ftseq_timebase #(
    parameter int FRAME_LEN = 5000,
    localparam int TW = $clog2(FRAME_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_en,
    output logic [TW-1:0] time_o,
    output logic          irq_o
);
    localparam logic [TW-1:0] LAST = TW'(FRAME_LEN - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          irq;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
        st_d.irq = irq_en && (st_q.cnt == LAST);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign time_o = st_q.cnt;
    assign irq_o  = st_q.irq;
endmodule

// File: rtl/ftseq_imem.sv
module ftseq_imem #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/ftseq_regs.sv
module ftseq_regs #(
    parameter int AW         = 5,
    parameter int DW         = 8,
    parameter int IRQ_ADDR   = 16,
    parameter int GAUGE_ADDR = 17,
    localparam int NREG = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic          dsp_irq,
    output logic          gauge_en
);
    logic [DW-1:0] regs_d [NREG];
    logic [DW-1:0] regs_q [NREG];

    always_comb begin
        regs_d = regs_q;
        if (we) regs_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{default: '0};
        else        regs_q <= regs_d;
    end

    assign rdata    = regs_q[raddr];
    assign dsp_irq  = regs_q[IRQ_ADDR][0];
    assign gauge_en = regs_q[GAUGE_ADDR][0];
endmodule

// File: rtl/frame_seq.sv
module frame_seq
    import ftseq_pkg::*;
#(
    parameter int IMEM_DEPTH = 64,
    parameter int FRAME_LEN  = 5000,
    localparam int PCW = $clog2(IMEM_DEPTH),
    localparam int TW  = $clog2(FRAME_LEN)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_imem_we,
    input  logic [PCW-1:0]       host_imem_addr,
    input  logic [INSTR_W-1:0]   host_imem_data,
    input  logic                 host_ctl_we,
    input  logic                 host_ctl_enable,
    input  logic                 host_rewind,
    input  logic                 host_frame_irq_en,
    input  logic [MV_ADDR_W-1:0] host_reg_addr,
    output logic [MV_DATA_W-1:0] host_reg_data,
    output logic [OPND_W-1:0]    synchro_val,
    output logic [OPND_W-1:0]    offset_val,
    output logic [TW-1:0]        frame_time,
    output logic                 idle,
    output logic                 frame_irq,
    output logic                 dsp_irq,
    output logic                 gauge_en
);
    typedef struct packed {
        logic              en;
        logic [PCW-1:0]    pc;
        logic [OPND_W-1:0] wait_cnt;
        logic [OPND_W-1:0] synchro;
        logic [OPND_W-1:0] offset;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic [INSTR_W-1:0]   instr;
    logic [PCW-1:0]       pc;
    logic                 exec_go;
    logic                 mv_we;
    op_e                  op;
    logic [OPND_W-1:0]    opnd;

    ftseq_timebase #(.FRAME_LEN(FRAME_LEN)) u_timebase (
        .clk    (clk),
        .rst_n  (rst_n),
        .irq_en (host_frame_irq_en),
        .time_o (frame_time),
        .irq_o  (frame_irq)
    );

    ftseq_imem #(.DEPTH(IMEM_DEPTH), .WIDTH(INSTR_W)) u_imem (
        .clk   (clk),
        .we    (host_imem_we),
        .waddr (host_imem_addr),
        .wdata (host_imem_data),
        .raddr (st_q.pc),
        .rdata (instr)
    );

    ftseq_regs #(.AW(MV_ADDR_W), .DW(MV_DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (mv_we),
        .waddr    (instr[MV_ADDR_W-1:0]),
        .wdata    (instr[MV_ADDR_W +: MV_DATA_W]),
        .raddr    (host_reg_addr),
        .rdata    (host_reg_data),
        .dsp_irq  (dsp_irq),
        .gauge_en (gauge_en)
    );

    assign op      = op_e'(instr[INSTR_W-1 -: 3]);
    assign opnd    = instr[OPND_W-1:0];
    assign pc      = st_q.pc;
    assign exec_go = st_q.en && (st_q.wait_cnt == '0) && !host_rewind && !host_ctl_we;

    always_comb begin
        st_d  = st_q;
        mv_we = 1'b0;

        if (st_q.en && st_q.wait_cnt != '0)
            st_d.wait_cnt = st_q.wait_cnt - 1'b1;

        if (exec_go) begin
            unique case (op)
                OP_SLEEP:   st_d.en = 1'b0;
                OP_AT: begin
                    if (opnd == OPND_W'(frame_time)) st_d.pc = st_q.pc + 1'b1;
                end
                OP_OFFSET: begin
                    st_d.offset = opnd;
                    st_d.pc     = st_q.pc + 1'b1;
                end
                OP_SYNCHRO: begin
                    st_d.synchro = opnd;
                    st_d.pc      = st_q.pc + 1'b1;
                end
                OP_MOVE: begin
                    mv_we   = 1'b1;
                    st_d.pc = st_q.pc + 1'b1;
                end
                OP_WAIT: begin
                    st_d.wait_cnt = opnd;
                    st_d.pc       = st_q.pc + 1'b1;
                end
                default:    st_d.pc = st_q.pc + 1'b1;
            endcase
        end

        if (host_rewind) begin
            st_d.pc       = '0;
            st_d.wait_cnt = '0;
        end

        if (host_ctl_we) begin
            if (host_ctl_enable && !st_q.en) begin
                st_d.en       = 1'b1;
                st_d.pc       = '0;
                st_d.wait_cnt = '0;
            end else if (!host_ctl_enable) begin
                st_d.en       = 1'b0;
                st_d.wait_cnt = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign synchro_val = st_q.synchro;
    assign offset_val  = st_q.offset;
    assign idle        = !st_q.en;
endmodule

// File: rtl/ftseq_chk.sv
module ftseq_chk #(
    parameter int FRAME_LEN = 5000,
    parameter int TW        = 13,
    parameter int PCW       = 6
) (
    input logic           clk,
    input logic           rst_n,
    input logic           host_ctl_we,
    input logic           host_ctl_enable,
    input logic           host_rewind,
    input logic [TW-1:0]  frame_time,
    input logic           frame_irq,
    input logic           idle,
    input logic [12:0]    synchro_val,
    input logic           exec_go,
    input logic [15:0]    instr,
    input logic [PCW-1:0] pc
);
    localparam logic [TW-1:0] LAST = TW'(FRAME_LEN - 1);

    assert_time_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_time <= LAST);

    assert_time_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> frame_time == (($past(frame_time) == LAST) ? '0 : $past(frame_time) + 1'b1));

    assert_irq_at_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_irq |-> frame_time == '0);

    assert_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ctl_we && host_ctl_enable) |=> !idle);

    assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ctl_we && host_ctl_enable && idle) |=> pc == '0);

    assert_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_go && instr[15:13] == 3'd0) |=> idle);

    assert_at_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_go && instr[15:13] == 3'd1 && instr[12:0] != 13'(frame_time)) |=> $stable(pc));

    assert_sync_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_go && instr[15:13] == 3'd3) |=> synchro_val == $past(instr[12:0]));

    assert_rewind_R11: assert property (@(posedge clk) disable iff (!rst_n)
        host_rewind |=> pc == '0);
endmodule

bind frame_seq ftseq_chk #(.FRAME_LEN(FRAME_LEN), .TW(TW), .PCW(PCW)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .host_ctl_we     (host_ctl_we),
    .host_ctl_enable (host_ctl_enable),
    .host_rewind     (host_rewind),
    .frame_time      (frame_time),
    .frame_irq       (frame_irq),
    .idle            (idle),
    .synchro_val     (synchro_val),
    .exec_go         (exec_go),
    .instr           (instr),
    .pc              (pc)
);

// File: tb/frame_seq_bench.sv
module frame_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_imem_we = 1'b0;
    logic [5:0]  host_imem_addr = '0;
    logic [15:0] host_imem_data = '0;
    logic        host_ctl_we = 1'b0;
    logic        host_ctl_enable = 1'b0;
    logic        host_rewind = 1'b0;
    logic        host_frame_irq_en = 1'b0;
    logic [4:0]  host_reg_addr = '0;
    logic [7:0]  host_reg_data;
    logic [12:0] synchro_val, offset_val, frame_time;
    logic        idle, frame_irq, dsp_irq, gauge_en;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    frame_seq u_frame_seq (.*);

    function automatic logic [15:0] enc(input int op, input int opnd);
        return {3'(op), 13'(opnd)};
    endfunction

    function automatic logic [15:0] mv(input int addr, input int data);
        return {3'd4, 8'(data), 5'(addr)};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic load(input int addr, input logic [15:0] w);
        host_imem_we   = 1'b1;
        host_imem_addr = 6'(addr);
        host_imem_data = w;
        @(negedge clk);
        host_imem_we   = 1'b0;
    endtask

    task automatic wait_time(input int t);
        while (int'(frame_time) != t) @(negedge clk);
    endtask

    // Enable at time t: after return, frame_time == t+1 and instr 0 executes now.
    task automatic start_at(input int t);
        wait_time(t);
        host_ctl_we     = 1'b1;
        host_ctl_enable = 1'b1;
        @(negedge clk);
        host_ctl_we     = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 idle", idle, 1);
        check("R1 synchro", synchro_val, 0);
        check("R1 offset", offset_val, 0);
        check("R1 frame_time", frame_time, 0);
        check("R1 frame_irq", frame_irq, 0);
        check("R1 dsp_irq", dsp_irq, 0);
        check("R1 gauge_en", gauge_en, 0);
        host_reg_addr = 5'd3;
        #0;
        check("R1 reg3", host_reg_data, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 first step", frame_time, 1);
    endtask

    task automatic t_timebase;
        host_frame_irq_en = 1'b1;
        wait_time(4998);
        @(negedge clk);
        check("R2 reach 4999", frame_time, 4999);
        check("R3 no irq at 4999", frame_irq, 0);
        @(negedge clk);
        check("R2 wrap to 0", frame_time, 0);
        check("R3 irq at wrap", frame_irq, 1);
        @(negedge clk);
        check("R3 irq one cycle", frame_irq, 0);
        host_frame_irq_en = 1'b0;
        wait_time(4999);
        @(negedge clk);
        check("R3 disabled irq", frame_irq, 0);
    endtask

    task automatic t_sync_offset;
        load(0, enc(3, 'h1234));
        load(1, enc(2, 'h0F0F));
        load(2, enc(0, 0));
        start_at(100);
        check("R4 idle low after enable", idle, 0);
        @(negedge clk);
        check("R8 synchro loaded", synchro_val, 'h1234);
        check("R8 offset not yet", offset_val, 0);
        @(negedge clk);
        check("R8 offset loaded", offset_val, 'h0F0F);
        @(negedge clk);
        check("R5 sleep idles", idle, 1);
    endtask

    task automatic t_sleep;
        load(0, enc(3, 9));
        load(1, enc(0, 0));
        load(2, enc(3, 10));
        start_at(200);
        @(negedge clk);
        check("R4 restart at address 0", synchro_val, 9);
        @(negedge clk);
        check("R5 idle after sleep", idle, 1);
        repeat (20) @(negedge clk);
        check("R5 later instr ignored", synchro_val, 9);
        check("R5 still idle", idle, 1);
    endtask

    task automatic t_at;
        load(0, enc(1, 300));
        load(1, enc(3, 77));
        load(2, enc(0, 0));
        start_at(250);
        wait_time(301);
        check("R6 held before target", synchro_val, 9);
        @(negedge clk);
        check("R6 next after target", synchro_val, 77);
        load(0, enc(1, 5));
        load(1, enc(3, 88));
        start_at(4990);
        wait_time(6);
        check("R6 wrap target not early", synchro_val, 77);
        @(negedge clk);
        check("R6 wrap target hit", synchro_val, 88);
    endtask

    task automatic t_wait;
        load(0, enc(3, 1));
        load(1, enc(5, 10));
        load(2, enc(3, 2));
        load(3, enc(0, 0));
        start_at(400);
        wait_time(413);
        check("R7 still waiting", synchro_val, 1);
        @(negedge clk);
        check("R7 after N ticks", synchro_val, 2);
        load(0, enc(5, 0));
        load(1, enc(3, 3));
        load(2, enc(0, 0));
        start_at(500);
        wait_time(503);
        check("R7 zero wait", synchro_val, 3);
    endtask

    task automatic t_move;
        load(0, mv(3, 'hA5));
        load(1, mv('h10, 1));
        load(2, mv('h11, 1));
        load(3, 16'hC000);
        load(4, 16'hFFFF);
        load(5, enc(3, 12));
        load(6, enc(0, 0));
        start_at(600);
        wait_time(610);
        host_reg_addr = 5'd3;
        #0;
        check("R9 reg3 data", host_reg_data, 'hA5);
        check("R9 dsp_irq set", dsp_irq, 1);
        check("R9 gauge_en set", gauge_en, 1);
        check("R10 passed opcodes 6 7", synchro_val, 12);
        host_reg_addr = 5'h1F;
        #0;
        check("R10 opcode 7 no write", host_reg_data, 0);
        load(0, mv('h10, 0));
        load(1, enc(0, 0));
        start_at(700);
        wait_time(710);
        check("R9 dsp_irq cleared", dsp_irq, 0);
        check("R9 gauge_en kept", gauge_en, 1);
    endtask

    task automatic t_rewind;
        load(0, enc(3, 40));
        load(1, enc(5, 2000));
        load(2, enc(3, 41));
        load(3, enc(0, 0));
        start_at(800);
        wait_time(850);
        load(0, enc(2, 55));
        host_rewind = 1'b1;
        @(negedge clk);
        host_rewind = 1'b0;
        @(negedge clk);
        check("R11 rewind runs address 0", offset_val, 55);
        check("R11 wait cancelled no skip", synchro_val, 40);
        host_ctl_we     = 1'b1;
        host_ctl_enable = 1'b0;
        @(negedge clk);
        host_ctl_we     = 1'b0;
        check("R4 disable by host", idle, 1);
    endtask

    initial begin
        t_reset();
        t_timebase();
        t_sync_offset();
        t_sleep();
        t_at();
        t_wait();
        t_move();
        t_rewind();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule